// File: doc/BRIEF.md
# Reconfigurable Gated Scan-Chain Wrapper

This block wraps a core whose internal state sits in three scan chains of 10, 5 and 4 flip-flops. At run time the wrapper maps those chains onto one, two or three TAM wires, so the core can be tested over as many wires as the test schedule grants it in a given session. The mapping and the gating mode are latched only while shifting is idle. The mapping can therefore be changed between shift sessions but never inside one.

In gated mode, every chain input is multiplexed straight from its wrapper chain's TAM input. A small shift-cycle counter opens the shift clock for one member chain of a wrapper chain at a time. It starts with the chain nearest scan-out, then takes the one before it, and so on. The scan-out multiplexer follows the active chain. A wrapper chain therefore loads and unloads in exactly the same number of cycles as in the plain concatenated mode, and gives the same serial stream, while fewer flip-flops toggle. A capture pulse loads every chain in parallel from the core side. A per-cycle count of clocked chains is provided for power checks.

Top module: `gated_scan_wrapper`

## Requirements
- R1: After reset, all chain contents are zero, the active mapping is 2'b00 with gating off, the error flag is low, the clocked-chain count is 0, and all three scan outputs are 0.
- R2: The mapping request `cfg_sel` and `gate_en` are latched on a clock edge where `shift_en` is low. Encodings: 2'b00 means one wire (chain order 10→5→4 on wire 0), 2'b01 means two wires (the 10 chain on wire 0, then 5→4 on wire 1), 2'b10 means three wires (10, 5 and 4 on wires 0, 1 and 2). A request of 2'b11 is latched as 2'b00.
- R3: In the one-wire mapping, a wrapper chain is 19 bits long, with the 10 chain at the input end, then the 5 chain, then the 4 chain at the output end. Each chain shifts from bit 0 toward its MSB, and wire 0 out is the 4 chain's MSB. After 19 shifts, the bit shifted in first sits in the MSB of the 4 chain. During those 19 cycles, the old contents appear on wire 0 MSB-first from the output end.
- R4: In the two-wire mapping, wire 0 carries the 10 chain alone and wire 1 carries the 5 chain followed by the 4 chain, a 9-bit wrapper chain. Scan output 2 stays 0.
- R5: In the three-wire mapping, each wire carries one chain, and each scan output is the MSB of its chain.
- R6: With gating on, at most one member chain of each wrapper chain is clocked per shift cycle. The count is 1 in the one-wire mapping and 2 in the two-wire mapping. With gating off it is 3.
- R7: With gating on, a multi-chain wrapper chain clocks the 4 chain for its first 4 shift cycles, then the 5 chain for 5 cycles, then (one-wire mapping only) the 10 chain for 10 cycles. Chains that are not clocked keep their contents.
- R8: For the same captured contents and the same serial input, gated and ungated modes give identical scan-out streams and identical final contents, in the same number of cycles.
- R9: The gating counter returns to its start whenever `shift_en` is low for a clock edge, so the next session begins with the chain nearest scan-out.
- R10: A capture pulse loads all three chains in parallel from their capture inputs. This holds in either gating mode and takes priority over a shift in the same cycle. That cycle does not advance the gating counter, and the clocked-chain count then reads 3.
- R11: A mapping or gating change requested while `shift_en` is high is ignored and sets `cfg_err`, which stays high until reset.
- R12: With neither shift nor capture active, the clocked-chain count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 2 | Requested wire mapping |
| gate_en | input | 1 | Requested gated-shift mode |
| shift_en | input | 1 | Shift session active |
| capture | input | 1 | Parallel capture pulse |
| tam_si | input | 3 | TAM scan-in bits, wire 0 in bit 0 |
| tam_so | output | 3 | TAM scan-out bits, wire 0 in bit 0 |
| cap_a | input | LEN_A | Capture data for the 10-bit chain |
| cap_b | input | LEN_B | Capture data for the 5-bit chain |
| cap_c | input | LEN_C | Capture data for the 4-bit chain |
| chain_a | output | LEN_A | Contents of the 10-bit chain |
| chain_b | output | LEN_B | Contents of the 5-bit chain |
| chain_c | output | LEN_C | Contents of the 4-bit chain |
| cfg_now | output | 2 | Latched wire mapping |
| gate_now | output | 1 | Latched gating mode |
| cfg_err | output | 1 | Sticky flag for a change requested mid-shift |
| active_cnt | output | 2 | Number of chains clocked this cycle |

## Verification
Two of the block's functions can coincide in one cycle.

The first is a capture pulse arriving while a gated shift session is running. The bench shifts two bits into the 4 chain, raises capture with `shift_en` still high, and then shifts twice more. Two things are judged: the chains must equal the capture data right after that cycle, and both later bits must still land in the 4 chain, which shows that the counter held.

The second is a mapping request arriving during shifting. The bench changes `cfg_sel` mid-session and checks that the latched mapping does not move and that the error flag rises. It then checks that the pending request takes effect on the first idle edge.

// File: rtl/gated_scan_wrapper.sv
module gated_scan_wrapper #(
  parameter int LEN_A = 10,
  parameter int LEN_B = 5,
  parameter int LEN_C = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_sel,
  input  logic             gate_en,
  input  logic             shift_en,
  input  logic             capture,
  input  logic [2:0]       tam_si,
  output logic [2:0]       tam_so,
  input  logic [LEN_A-1:0] cap_a,
  input  logic [LEN_B-1:0] cap_b,
  input  logic [LEN_C-1:0] cap_c,
  output logic [LEN_A-1:0] chain_a,
  output logic [LEN_B-1:0] chain_b,
  output logic [LEN_C-1:0] chain_c,
  output logic [1:0]       cfg_now,
  output logic             gate_now,
  output logic             cfg_err,
  output logic [1:0]       active_cnt
);
  localparam int TOT  = LEN_A + LEN_B + LEN_C;
  localparam int TAIL = LEN_B + LEN_C;
  localparam int CW   = $clog2(TOT + 1);

  logic [CW-1:0] cnt;
  logic [1:0]    cfg_req;
  logic          one_w, two_w, three_w;
  logic          shifting, seq_on, seq_a, seq_b, seq_c;
  logic          en_a, en_b, en_c;
  logic          in_b, in_c, so_a, so_b, so_c, so_seq;
  logic [CW-1:0] period;

  assign cfg_req  = (cfg_sel == 2'b11) ? 2'b00 : cfg_sel;
  assign one_w    = (cfg_now == 2'b00);
  assign two_w    = (cfg_now == 2'b01);
  assign three_w  = (cfg_now == 2'b10);
  assign shifting = shift_en & ~capture;
  assign period   = one_w ? CW'(TOT) : CW'(TAIL);

  assign seq_c  = (cnt < CW'(LEN_C));
  assign seq_b  = (cnt >= CW'(LEN_C)) && (cnt < CW'(TAIL));
  assign seq_a  = (cnt >= CW'(TAIL));
  assign seq_on = gate_now & (one_w | two_w);

  assign en_a = shifting & ((gate_now & one_w) ? seq_a : 1'b1);
  assign en_b = shifting & (seq_on ? seq_b : 1'b1);
  assign en_c = shifting & (seq_on ? seq_c : 1'b1);

  assign so_a = chain_a[LEN_A-1];
  assign so_b = chain_b[LEN_B-1];
  assign so_c = chain_c[LEN_C-1];
  assign so_seq = seq_c ? so_c : (seq_b ? so_b : so_a);

  assign in_b = one_w ? (gate_now ? tam_si[0] : so_a) : tam_si[1];
  assign in_c = three_w ? tam_si[2] :
                gate_now ? (one_w ? tam_si[0] : tam_si[1]) : so_b;

  assign tam_so[0] = one_w ? (gate_now ? so_seq : so_c) : so_a;
  assign tam_so[1] = two_w ? (gate_now ? so_seq : so_c) : (three_w ? so_b : 1'b0);
  assign tam_so[2] = three_w ? so_c : 1'b0;

  assign active_cnt = capture ? 2'd3 : ({1'b0, en_a} + {1'b0, en_b} + {1'b0, en_c});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_a <= '0;
      chain_b <= '0;
      chain_c <= '0;
    end else if (capture) begin
      chain_a <= cap_a;
      chain_b <= cap_b;
      chain_c <= cap_c;
    end else begin
      if (en_a) chain_a <= {chain_a[LEN_A-2:0], tam_si[0]};
      if (en_b) chain_b <= {chain_b[LEN_B-2:0], in_b};
      if (en_c) chain_c <= {chain_c[LEN_C-2:0], in_c};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (!shift_en)
      cnt <= '0;
    else if (shifting)
      cnt <= (cnt == period - CW'(1)) ? '0 : cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_now  <= 2'b00;
      gate_now <= 1'b0;
      cfg_err  <= 1'b0;
    end else if (!shift_en) begin
      cfg_now  <= cfg_req;
      gate_now <= gate_en;
    end else if ((cfg_req != cfg_now) || (gate_en != gate_now)) begin
      cfg_err  <= 1'b1;
    end
  end
endmodule

module gated_scan_wrapper_chk #(
  parameter int LEN_A = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_en,
  input logic             capture,
  input logic [2:0]       tam_so,
  input logic [LEN_A-1:0] cap_a,
  input logic [LEN_A-1:0] chain_a,
  input logic [1:0]       cfg_now,
  input logic             gate_now,
  input logic             cfg_err,
  input logic [1:0]       active_cnt
);
  a_r2_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_now != 2'b11);

  a_r5_spare_out_low: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_now != 2'b10 |-> tam_so[2] == 1'b0);

  a_r6_one_per_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_now && cfg_now == 2'b00 && shift_en && !capture) |-> active_cnt == 2'd1);

  a_r10_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> chain_a == $past(cap_a));

  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> cfg_now == $past(cfg_now) && gate_now == $past(gate_now));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !capture) |-> active_cnt == 2'd0);
endmodule

bind gated_scan_wrapper gated_scan_wrapper_chk #(.LEN_A(LEN_A)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .capture(capture),
  .tam_so(tam_so), .cap_a(cap_a), .chain_a(chain_a), .cfg_now(cfg_now),
  .gate_now(gate_now), .cfg_err(cfg_err), .active_cnt(active_cnt)
);

// File: tb/gated_scan_wrapper_bench.sv
`timescale 1ns/1ps
module gated_scan_wrapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_sel = 2'b00;
  logic        gate_en = 1'b0, shift_en = 1'b0, capture = 1'b0;
  logic [2:0]  tam_si = 3'b000;
  logic [2:0]  tam_so;
  logic [9:0]  cap_a = '0, chain_a;
  logic [4:0]  cap_b = '0, chain_b;
  logic [3:0]  cap_c = '0, chain_c;
  logic [1:0]  cfg_now, active_cnt;
  logic        gate_now, cfg_err;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  gated_scan_wrapper u_gated_scan_wrapper (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .gate_en(gate_en),
    .shift_en(shift_en), .capture(capture), .tam_si(tam_si), .tam_so(tam_so),
    .cap_a(cap_a), .cap_b(cap_b), .cap_c(cap_c), .chain_a(chain_a),
    .chain_b(chain_b), .chain_c(chain_c), .cfg_now(cfg_now), .gate_now(gate_now),
    .cfg_err(cfg_err), .active_cnt(active_cnt)
  );

  // {cfg, gate, captured contents {C,B,A}, serial pattern (bit 0 first)}
  localparam logic [40:0] VEC [4] = '{
    {2'b00, 1'b0, 19'h5A3C1, 19'h2B6E9},
    {2'b00, 1'b1, 19'h5A3C1, 19'h2B6E9},
    {2'b11, 1'b1, 19'h7F00D, 19'h10F0F},
    {2'b00, 1'b1, 19'h00000, 19'h7FFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic load(input logic [1:0] cfg, input logic gate, input logic [18:0] w);
    @(negedge clk);
    shift_en = 1'b0; cfg_sel = cfg; gate_en = gate; capture = 1'b1;
    {cap_c, cap_b, cap_a} = w;
    @(negedge clk);
    capture = 1'b0;
  endtask

  // R3 / R8: one-wire mapping, gated or not
  task automatic run_one(input logic [1:0] cfg, input logic gate,
                         input logic [18:0] w, input logic [18:0] p);
    logic [18:0] rev;
    load(cfg, gate, w);
    #1 chk("R2 latched mapping", {29'd0, gate_now, cfg_now}, {29'd0, gate, 2'b00});
    for (int k = 0; k < 19; k++) begin
      if (k > 0) @(negedge clk);
      shift_en = 1'b1; tam_si = {2'b00, p[k]};
      #1 chk("R3/R8 wire0 stream", {31'd0, tam_so[0]}, {31'd0, w[18-k]});
      chk("R6 clocked count", {30'd0, active_cnt}, gate ? 32'd1 : 32'd3);
    end
    @(negedge clk);
    shift_en = 1'b0;
    for (int i = 0; i < 19; i++) rev[18-i] = p[i];
    #1 chk("R3/R8 final contents", {13'd0, chain_c, chain_b, chain_a}, {13'd0, rev});
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    logic [18:0] w;
    logic [8:0]  q;
    logic [8:0]  rq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 chains", {13'd0, chain_c, chain_b, chain_a}, 32'd0);
    chk("R1 mapping", {29'd0, gate_now, cfg_now}, 32'd0);
    chk("R1 err", {31'd0, cfg_err}, 32'd0);
    chk("R12 idle count", {30'd0, active_cnt}, 32'd0);
    chk("R1 scan out", {29'd0, tam_so}, 32'd0);

    for (int v = 0; v < 4; v++)
      run_one(VEC[v][40:39], VEC[v][38], VEC[v][37:19], VEC[v][18:0]);

    // R4: two wires, both gating modes
    for (int g = 0; g < 2; g++) begin
      w = 19'h36A5B; q = 9'h14D;
      load(2'b01, g[0], w);
      for (int k = 0; k < 9; k++) begin
        if (k > 0) @(negedge clk);
        shift_en = 1'b1; tam_si = {1'b0, q[k], 1'b0};
        #1 chk("R4 wire1 stream", {31'd0, tam_so[1]}, {31'd0, w[18-k]});
        chk("R4 wire0 stream", {31'd0, tam_so[0]}, {31'd0, w[9-k]});
        chk("R4 spare out", {31'd0, tam_so[2]}, 32'd0);
        chk("R6 two-wire count", {30'd0, active_cnt}, g ? 32'd2 : 32'd3);
      end
      @(negedge clk);
      shift_en = 1'b0;
      for (int i = 0; i < 9; i++) rq[8-i] = q[i];
      #1 chk("R4 wire1 final", {23'd0, chain_c, chain_b}, {23'd0, rq});
    end

    // R5: three wires
    w = 19'h4C3A9;
    load(2'b10, 1'b1, w);
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      shift_en = 1'b1; tam_si = 3'b000;
      #1 chk("R5 outputs", {29'd0, tam_so}, {29'd0, w[18-k], w[14-k], w[9-k]});
      chk("R6 three-wire count", {30'd0, active_cnt}, 32'd3);
    end
    @(negedge clk); shift_en = 1'b0;

    // R7 / R9: gated order and counter restart
    load(2'b00, 1'b1, 19'd0);
    shift_en = 1'b1; tam_si = 3'b001;
    repeat (6) @(negedge clk);
    shift_en = 1'b0;
    #1 chk("R7 order", {13'd0, chain_c, chain_b, chain_a}, {13'd0, 4'hF, 5'b00011, 10'd0});
    @(negedge clk);
    shift_en = 1'b1; tam_si = 3'b000;
    repeat (4) @(negedge clk);
    shift_en = 1'b0;
    #1 chk("R9 restart", {13'd0, chain_c, chain_b, chain_a}, {13'd0, 4'h0, 5'b00011, 10'd0});

    // R10: capture coinciding with a gated shift
    @(negedge clk);
    cap_a = 10'h2A5; cap_b = 5'h16; cap_c = 4'h9;
    shift_en = 1'b1; tam_si = 3'b001;
    repeat (2) @(negedge clk);
    capture = 1'b1;
    #1 chk("R10 count on capture", {30'd0, active_cnt}, 32'd3);
    @(negedge clk);
    capture = 1'b0; tam_si = 3'b000;
    #1 chk("R10 parallel load", {13'd0, chain_c, chain_b, chain_a}, {13'd0, 4'h9, 5'h16, 10'h2A5});
    repeat (2) @(negedge clk);
    shift_en = 1'b0;
    #1 chk("R10 counter held", {23'd0, chain_c, chain_b}, {23'd0, 4'h4, 5'h16});

    // R11: mapping request during shifting
    @(negedge clk);
    cfg_sel = 2'b00; gate_en = 1'b0;
    @(negedge clk);
    #1 chk("R11 err clear before", {31'd0, cfg_err}, 32'd0);
    shift_en = 1'b1;
    @(negedge clk);
    cfg_sel = 2'b10;
    repeat (2) @(negedge clk);
    #1 chk("R11 mapping frozen", {30'd0, cfg_now}, 32'd0);
    chk("R11 err raised", {31'd0, cfg_err}, 32'd1);
    shift_en = 1'b0;
    @(negedge clk);
    #1 chk("R2 pending applied", {30'd0, cfg_now}, 32'd2);
    chk("R11 err sticky", {31'd0, cfg_err}, 32'd1);

    report();
  end
endmodule